// File: doc/BRIEF.md
# Terminal Adapter Connection Controller

This block is the frame-level connection controller of a rate-adapting terminal adapter. It does not shift bits. It sees whole frames as parallel fields. A received frame has 48 data bits, 9 status bits and 2 extra control bits. The 7 E bits of a received frame carry nothing this block acts on, so they are not an input. A transmit request asks the block for one outgoing frame, and it returns that frame with all four fields filled according to its current state.

Five states make up the connection handshake:

| Code | State |
|------|-------|
| 0 | idle |
| 1 | connecting |
| 2 | data |
| 3 | disconnecting |
| 4 | resyncing |

Three things drive it: the local DTR level, sync and out-of-sync pulses from the lower layer, and the S and X bits of received frames. Connecting, disconnecting and resyncing each arm a timeout. The timeouts count a shared tick-enable input, so a bench can shorten them.

The block drives the CTS, DSR and DCD circuit levels, an 8-bit status word with a one-cycle change pulse, and the received data bits passed up to the terminal. It also brings its state code out as a port.

Top module: `ta_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle), CTS, DSR and DCD are 0 (OFF), status is 0x00, and tx_valid and up_valid are 0.
- R2: In idle, every bit of an outgoing frame is 1, every received frame is passed up as 48 ones, and the three circuits and the status stay OFF/0.
- R3: A rising DTR in idle moves to connecting (code 1). DTR low in connecting returns to idle.
- R4: In connecting, before any sync pulse, S and X are sent as all ones. After a sync pulse they are sent as all zeros. D and E are all ones in both cases.
- R5: In connecting, a received frame counts as ON when all 9 S bits are 0 and both X bits are 0. A frame that is not ON leaves the state unchanged and is passed up as all ones. An ON frame moves the block to data (code 2), sets CTS, DSR and DCD ON and status 0x1E, and passes its own data bits up.
- R6: In data, S and X are sent as zeros, D carries tx_data, and tx_e is 7'b1111110. Bit 0 of tx_e is E1, so E1..E3 read 0,1,1 and E4..E7 are 1.
- R7: DTR low in data moves to disconnecting (code 3) with status 0x14, CTS OFF, and DSR and DCD still ON. While disconnecting, S is sent as ones, X as zeros, D as zeros and E as ones.
- R8: In disconnecting, a received frame with all S bits 0 is passed up unchanged and does not change the state. A frame with any S bit 1, or an out-of-sync pulse, returns the block to idle with status 0x00 and all circuits OFF, and that frame is passed up as ones.
- R9: In data, a received frame counts as a remote disconnect when its S bits are not all 0, its X bits are 0 and all its D bits are 0. Such a frame sets DSR and DCD OFF and status 0x0A, and the state stays data. A later DTR low then moves to disconnecting with status 0x00.
- R10: An out-of-sync pulse in data moves to resyncing (code 4). In resyncing, S is sent as zeros, X as ones and D as tx_data. A sync pulse in resyncing returns to data.
- R11: Each timeout expires on its N-th tick after the state is entered: T1_TICKS in connecting, T2_TICKS in disconnecting and X1_TICKS in resyncing. Expiry in connecting or disconnecting returns to idle. Expiry in resyncing moves to disconnecting with status 0x14 and CTS OFF. Idle reached by expiry is not left again until DTR rises anew.
- R12: status_chg is 1 for exactly the one cycle after each clock edge that changes status.
- R13: tx_valid is 1 exactly one cycle after tx_req is 1, and up_valid is 1 exactly one cycle after rx_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timeout tick enable |
| dtr_on | input | 1 | Local DTR level, 1 = ON |
| sync_ind | input | 1 | Lower layer reached sync (pulse) |
| desync_ind | input | 1 | Lower layer lost sync (pulse) |
| rx_valid | input | 1 | Received frame present |
| rx_d | input | 48 | Received D bits |
| rx_s | input | 9 | Received S bits (0 = ON) |
| rx_x | input | 2 | Received X bits (0 = ON) |
| tx_req | input | 1 | Request one outgoing frame |
| tx_data | input | 48 | Terminal data for outgoing D bits |
| tx_valid | output | 1 | Outgoing frame fields valid |
| tx_d | output | 48 | Outgoing D bits |
| tx_e | output | 7 | Outgoing E bits, bit 0 = E1 |
| tx_s | output | 9 | Outgoing S bits |
| tx_x | output | 2 | Outgoing X bits |
| cts | output | 1 | CTS circuit, 1 = ON |
| dsr | output | 1 | DSR circuit, 1 = ON |
| dcd | output | 1 | DCD circuit, 1 = ON |
| status | output | 8 | Connection status word |
| status_chg | output | 1 | One-cycle pulse on status change |
| up_valid | output | 1 | Data passed up valid |
| up_d | output | 48 | D bits passed up to the terminal |
| state | output | 3 | Current state code |

## Verification
Received frames are driven in four patterns:
- S and X both OFF.
- S and X both ON.
- S OFF with X ON and non-zero data.
- S OFF with X ON and all-zero data.

Each pattern is sent in several states. This separates three things: a frame that must be ignored, a frame that completes the connection, and one that signals a remote disconnect. It also shows whether the passed-up data is the real payload or forced ones.

Outgoing frames are requested in every state. For the connecting state they are requested both before and after a sync pulse, which confirms each fill rule and the E1..E3 rate code. Tick counts are stepped to one short of each timeout and then to the timeout itself, which pins down the exact expiry tick.

// File: rtl/ta_pkg.sv
package ta_pkg;

  localparam int D_BITS = 48;
  localparam int E_BITS = 7;
  localparam int S_BITS = 9;
  localparam int X_BITS = 2;

  typedef enum logic [2:0] {
    TA_IDLE   = 3'd0,
    TA_CONN   = 3'd1,
    TA_DATA   = 3'd2,
    TA_DISC   = 3'd3,
    TA_RESYNC = 3'd4
  } ta_state_e;

  typedef struct packed {
    logic [D_BITS-1:0] d;
    logic [E_BITS-1:0] e;
    logic [S_BITS-1:0] s;
    logic [X_BITS-1:0] x;
  } ta_frame_t;

  localparam logic [7:0] STAT_UP    = 8'h1E;
  localparam logic [7:0] STAT_LDISC = 8'h14;
  localparam logic [7:0] STAT_RDISC = 8'h0A;
  localparam logic [7:0] STAT_DOWN  = 8'h00;

  // E1 = bit 0 = 0, E2 = E3 = 1 selects the 9600 bit/s code
  localparam logic [E_BITS-1:0] E_RATE = 7'b1111110;

  function automatic logic s_is_on(input logic [S_BITS-1:0] s);
    return s == '0;
  endfunction

  function automatic logic x_is_on(input logic [X_BITS-1:0] x);
    return x == '0;
  endfunction

endpackage

// File: rtl/ta_timer.sv
module ta_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);

  logic [W-1:0] cnt;

  // expiry does not look at load, so no loop through the FSM
  assign expire = tick && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - W'(1);
  end

endmodule

// File: rtl/ta_txfill.sv
module ta_txfill
  import ta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ta_state_e         state,
  input  logic              synced,
  input  logic              tx_req,
  input  logic [D_BITS-1:0] tx_data,
  output logic              tx_valid,
  output ta_frame_t         frame
);

  function automatic ta_frame_t fill(input ta_state_e st, input logic syn,
                                     input logic [D_BITS-1:0] data);
    ta_frame_t f;
    f = '1;
    case (st)
      TA_CONN: begin
        f.s = syn ? '0 : '1;
        f.x = syn ? '0 : '1;
      end
      TA_DATA: begin
        f.s = '0;
        f.x = '0;
        f.d = data;
        f.e = E_RATE;
      end
      TA_RESYNC: begin
        f.s = '0;
        f.d = data;
        f.e = E_RATE;
      end
      TA_DISC: begin
        f.x = '0;
        f.d = '0;
      end
      default: ;
    endcase
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      frame    <= '1;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) frame <= fill(state, synced, tx_data);
    end
  end

endmodule

// File: rtl/ta_fsm.sv
module ta_fsm
  import ta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dtr_on,
  input  logic              sync_ind,
  input  logic              desync_ind,
  input  logic              rx_valid,
  input  logic [D_BITS-1:0] rx_d,
  input  logic [S_BITS-1:0] rx_s,
  input  logic [X_BITS-1:0] rx_x,
  input  logic              tmr_expire,
  output ta_state_e         state,
  output ta_state_e         state_nxt,
  output logic              state_chg,
  output logic              synced,
  output logic              cts,
  output logic              dsr,
  output logic              dcd,
  output logic [7:0]        status,
  output logic              status_chg,
  output logic              up_valid,
  output logic [D_BITS-1:0] up_d
);

  logic       dtr_q, syn_n, cts_n, dsr_n, dcd_n;
  logic [7:0] stat_n;

  // named events for the checker and for readability
  logic dtr_rise, frm_on, frm_rdisc, frm_s_off;
  assign dtr_rise  = dtr_on && !dtr_q;
  assign frm_on    = rx_valid && s_is_on(rx_s) && x_is_on(rx_x);
  assign frm_s_off = rx_valid && !s_is_on(rx_s);
  assign frm_rdisc = frm_s_off && x_is_on(rx_x) && (rx_d == '0);

  always_comb begin
    state_nxt = state;
    syn_n  = synced;
    cts_n  = cts;
    dsr_n  = dsr;
    dcd_n  = dcd;
    stat_n = status;
    if (sync_ind) syn_n = 1'b1;
    case (state)
      TA_IDLE: if (dtr_rise) state_nxt = TA_CONN;
      TA_CONN: begin
        if (!dtr_on) state_nxt = TA_IDLE;
        else if (frm_on) begin
          state_nxt = TA_DATA;
          {cts_n, dsr_n, dcd_n} = 3'b111;
          stat_n = STAT_UP;
        end else if (tmr_expire) state_nxt = TA_IDLE;
      end
      TA_DATA: begin
        if (!dtr_on) state_nxt = TA_DISC;
        else if (desync_ind) state_nxt = TA_RESYNC;
        else if (frm_rdisc) begin
          {dsr_n, dcd_n} = 2'b00;
          stat_n = STAT_RDISC;
        end
      end
      TA_RESYNC: begin
        if (!dtr_on || tmr_expire) state_nxt = TA_DISC;
        else if (sync_ind) state_nxt = TA_DATA;
      end
      TA_DISC: if (desync_ind || tmr_expire || frm_s_off) state_nxt = TA_IDLE;
      default: state_nxt = TA_IDLE;
    endcase
    // entering disconnecting: remote-disconnect memory is DSR already OFF
    if (state_nxt == TA_DISC && state != TA_DISC) begin
      cts_n  = 1'b0;
      stat_n = dsr ? STAT_LDISC : STAT_DOWN;
    end
    if (state_nxt == TA_CONN && state != TA_CONN) syn_n = 1'b0;
    if (state_nxt == TA_IDLE) begin
      {cts_n, dsr_n, dcd_n} = 3'b000;
      stat_n = STAT_DOWN;
      syn_n  = 1'b0;
    end
  end

  assign state_chg = (state_nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= TA_IDLE;
      dtr_q      <= 1'b0;
      synced     <= 1'b0;
      {cts, dsr, dcd} <= 3'b000;
      status     <= STAT_DOWN;
      status_chg <= 1'b0;
      up_valid   <= 1'b0;
      up_d       <= '1;
    end else begin
      state      <= state_nxt;
      dtr_q      <= dtr_on;
      synced     <= syn_n;
      {cts, dsr, dcd} <= {cts_n, dsr_n, dcd_n};
      status     <= stat_n;
      status_chg <= (stat_n != status);
      up_valid   <= rx_valid;
      if (rx_valid)
        up_d <= (state_nxt inside {TA_DATA, TA_RESYNC, TA_DISC}) ? rx_d : '1;
    end
  end

endmodule

// File: rtl/ta_ctrl.sv
module ta_ctrl
  import ta_pkg::*;
#(
  parameter int T1_TICKS = 10,
  parameter int T2_TICKS = 5,
  parameter int X1_TICKS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                dtr_on,
  input  logic                sync_ind,
  input  logic                desync_ind,
  input  logic                rx_valid,
  input  logic [D_BITS-1:0]   rx_d,
  input  logic [S_BITS-1:0]   rx_s,
  input  logic [X_BITS-1:0]   rx_x,
  input  logic                tx_req,
  input  logic [D_BITS-1:0]   tx_data,
  output logic                tx_valid,
  output logic [D_BITS-1:0]   tx_d,
  output logic [E_BITS-1:0]   tx_e,
  output logic [S_BITS-1:0]   tx_s,
  output logic [X_BITS-1:0]   tx_x,
  output logic                cts,
  output logic                dsr,
  output logic                dcd,
  output logic [7:0]          status,
  output logic                status_chg,
  output logic                up_valid,
  output logic [D_BITS-1:0]   up_d,
  output logic [2:0]          state
);

  localparam int TMAX = (T1_TICKS > T2_TICKS)
                        ? ((T1_TICKS > X1_TICKS) ? T1_TICKS : X1_TICKS)
                        : ((T2_TICKS > X1_TICKS) ? T2_TICKS : X1_TICKS);
  localparam int TW = $clog2(TMAX + 1);

  function automatic logic [TW-1:0] timeout_of(input ta_state_e st);
    case (st)
      TA_CONN:   return TW'(T1_TICKS);
      TA_DISC:   return TW'(T2_TICKS);
      TA_RESYNC: return TW'(X1_TICKS);
      default:   return '0;
    endcase
  endfunction

  ta_state_e st_q, st_nxt;
  logic      st_chg, synced, tmr_expire;
  ta_frame_t frame;

  ta_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (st_chg),
    .load_val (timeout_of(st_nxt)),
    .expire   (tmr_expire)
  );

  ta_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .dtr_on     (dtr_on),
    .sync_ind   (sync_ind),
    .desync_ind (desync_ind),
    .rx_valid   (rx_valid),
    .rx_d       (rx_d),
    .rx_s       (rx_s),
    .rx_x       (rx_x),
    .tmr_expire (tmr_expire),
    .state      (st_q),
    .state_nxt  (st_nxt),
    .state_chg  (st_chg),
    .synced     (synced),
    .cts        (cts),
    .dsr        (dsr),
    .dcd        (dcd),
    .status     (status),
    .status_chg (status_chg),
    .up_valid   (up_valid),
    .up_d       (up_d)
  );

  ta_txfill u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (st_q),
    .synced   (synced),
    .tx_req   (tx_req),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .frame    (frame)
  );

  assign tx_d  = frame.d;
  assign tx_e  = frame.e;
  assign tx_s  = frame.s;
  assign tx_x  = frame.x;
  assign state = st_q;

endmodule

// File: rtl/ta_ctrl_chk.sv
module ta_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       dtr_on,
  input logic       cts,
  input logic       dsr,
  input logic       dcd,
  input logic [7:0] status,
  input logic       status_chg,
  input logic       tx_req,
  input logic       tx_valid,
  input logic [8:0] tx_s,
  input logic [1:0] tx_x,
  input logic [6:0] tx_e,
  input logic       rx_valid,
  input logic       up_valid
);

  // R2
  idle_circ_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> (!cts && !dsr && !dcd && status == 8'h00));

  // R12
  status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_chg == (status != $past(status)));

  // R13
  tx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_valid);

  // R13
  up_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> up_valid);

  // R6
  data_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && state == 3'd2) |=> (tx_s == 9'd0 && tx_x == 2'd0 && tx_e == 7'b1111110));

  // R7
  local_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && !dtr_on) |=> (state == 3'd3 && !cts));

  // R10
  resync_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && state == 3'd4) |=> (tx_s == 9'd0 && tx_x == 2'b11));

endmodule

bind ta_ctrl ta_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state),
  .dtr_on     (dtr_on),
  .cts        (cts),
  .dsr        (dsr),
  .dcd        (dcd),
  .status     (status),
  .status_chg (status_chg),
  .tx_req     (tx_req),
  .tx_valid   (tx_valid),
  .tx_s       (tx_s),
  .tx_x       (tx_x),
  .tx_e       (tx_e),
  .rx_valid   (rx_valid),
  .up_valid   (up_valid)
);

// File: tb/ta_ctrl_tb.sv
module ta_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n, tick, dtr_on, sync_ind, desync_ind, rx_valid, tx_req;
  logic [47:0] rx_d, tx_data, tx_d, up_d;
  logic [8:0]  rx_s, tx_s;
  logic [1:0]  rx_x, tx_x;
  logic [6:0]  tx_e;
  logic        tx_valid, cts, dsr, dcd, status_chg, up_valid;
  logic [7:0]  status;
  logic [2:0]  state;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [47:0] ALT  = {24{2'b01}};
  localparam logic [47:0] ONES = '1;

  always #2 clk = ~clk;

  ta_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dtr_on(dtr_on),
    .sync_ind(sync_ind), .desync_ind(desync_ind),
    .rx_valid(rx_valid), .rx_d(rx_d), .rx_s(rx_s), .rx_x(rx_x),
    .tx_req(tx_req), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_d(tx_d), .tx_e(tx_e), .tx_s(tx_s), .tx_x(tx_x),
    .cts(cts), .dsr(dsr), .dcd(dcd), .status(status),
    .status_chg(status_chg), .up_valid(up_valid), .up_d(up_d),
    .state(state)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; dtr_on = 0; sync_ind = 0; desync_ind = 0;
    rx_valid = 0; rx_d = '0; rx_s = '1; rx_x = '1; tx_req = 0; tx_data = '0;
    step(3);
    rst_n = 1;
    step(1);
  endtask

  task automatic set_dtr(input logic v);
    dtr_on = v; step(1);
  endtask

  task automatic pulse_sync();
    sync_ind = 1; step(1); sync_ind = 0;
  endtask

  task automatic pulse_desync();
    desync_ind = 1; step(1); desync_ind = 0;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(1); tick = 0;
    end
  endtask

  task automatic send_rx(input logic [47:0] d, input logic [8:0] s, input logic [1:0] x);
    rx_valid = 1; rx_d = d; rx_s = s; rx_x = x;
    step(1);
    rx_valid = 0;
  endtask

  task automatic req_tx(input logic [47:0] data);
    tx_req = 1; tx_data = data;
    step(1);
    tx_req = 0;
  endtask

  task automatic reach_data();
    do_reset();
    set_dtr(1);
    pulse_sync();
    send_rx(ALT, 9'd0, 2'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", 64'(state), 64'd0);
    chk("R1 circuits", 64'({cts, dsr, dcd}), 64'd0);
    chk("R1 status", 64'(status), 64'h00);
    chk("R1 valids", 64'({tx_valid, up_valid}), 64'd0);
  endtask

  task automatic t_idle();
    do_reset();
    req_tx(ALT);
    chk("R13 tx_valid", 64'(tx_valid), 64'd1);
    chk("R2 idle tx d", 64'(tx_d), 64'(ONES));
    chk("R2 idle tx e/s/x", 64'({tx_e, tx_s, tx_x}), 64'h3FFFF);
    send_rx(ALT, 9'd0, 2'd0);
    chk("R13 up_valid", 64'(up_valid), 64'd1);
    chk("R2 idle up ones", 64'(up_d), 64'(ONES));
    chk("R2 idle stays", 64'({state, cts, dsr, dcd, status}), 64'd0);
    step(1);
    chk("R13 up_valid drop", 64'(up_valid), 64'd0);
  endtask

  task automatic t_connect();
    do_reset();
    set_dtr(1);
    chk("R3 dtr rise", 64'(state), 64'd1);
    set_dtr(0);
    chk("R3 dtr fall", 64'(state), 64'd0);
    set_dtr(1);
    chk("R3 dtr rise again", 64'(state), 64'd1);
    req_tx(ALT);
    chk("R4 pre-sync s/x", 64'({tx_s, tx_x}), 64'h7FF);
    chk("R4 pre-sync d/e", 64'({tx_d, tx_e}), {9'd0, ONES, 7'h7F});
    pulse_sync();
    req_tx(ALT);
    chk("R4 post-sync s/x", 64'({tx_s, tx_x}), 64'd0);
    chk("R4 post-sync d/e", 64'({tx_d, tx_e}), {9'd0, ONES, 7'h7F});
    send_rx(ALT, 9'h1FF, 2'b11);
    chk("R5 off frame state", 64'(state), 64'd1);
    chk("R5 off frame up", 64'(up_d), 64'(ONES));
    send_rx(ALT, 9'd0, 2'd0);
    chk("R5 on frame state", 64'(state), 64'd2);
    chk("R5 circuits on", 64'({cts, dsr, dcd}), 64'd7);
    chk("R5 status", 64'(status), 64'h1E);
    chk("R5 up real d", 64'(up_d), 64'(ALT));
    chk("R12 pulse", 64'(status_chg), 64'd1);
    step(1);
    chk("R12 pulse one cycle", 64'(status_chg), 64'd0);
  endtask

  task automatic t_data();
    reach_data();
    req_tx(48'hABCDEF123456);
    chk("R6 s/x", 64'({tx_s, tx_x}), 64'd0);
    chk("R6 d", 64'(tx_d), 64'h0000ABCDEF123456);
    chk("R6 e rate", 64'(tx_e), 64'b1111110);
  endtask

  task automatic t_local_disc();
    reach_data();
    set_dtr(0);
    chk("R7 state", 64'(state), 64'd3);
    chk("R7 status", 64'(status), 64'h14);
    chk("R7 circuits", 64'({cts, dsr, dcd}), 64'b011);
    req_tx(ALT);
    chk("R7 d zero", 64'(tx_d), 64'd0);
    chk("R7 e/s/x", 64'({tx_e, tx_s, tx_x}), {46'd0, 7'h7F, 9'h1FF, 2'b00});
    send_rx(ALT, 9'd0, 2'd0);
    chk("R8 s on ignored", 64'(state), 64'd3);
    chk("R8 s on passes d", 64'(up_d), 64'(ALT));
    send_rx(ALT, 9'h1FF, 2'd0);
    chk("R8 s off idle", 64'(state), 64'd0);
    chk("R8 status/circ", 64'({status, cts, dsr, dcd}), 64'd0);
    chk("R8 up ones", 64'(up_d), 64'(ONES));
  endtask

  task automatic t_remote_disc();
    reach_data();
    send_rx(48'd0, 9'h1FF, 2'd0);
    chk("R9 state stays", 64'(state), 64'd2);
    chk("R9 status", 64'(status), 64'h0A);
    chk("R9 circuits", 64'({cts, dsr, dcd}), 64'b100);
    set_dtr(0);
    chk("R9 disc state", 64'(state), 64'd3);
    chk("R9 disc status", 64'(status), 64'h00);
    pulse_desync();
    chk("R8 desync idle", 64'(state), 64'd0);
  endtask

  task automatic t_resync();
    reach_data();
    pulse_desync();
    chk("R10 resync", 64'(state), 64'd4);
    req_tx(ALT);
    chk("R10 s/x", 64'({tx_s, tx_x}), 64'b11);
    chk("R10 d", 64'(tx_d), 64'(ALT));
    pulse_sync();
    chk("R10 back to data", 64'(state), 64'd2);
    req_tx(ALT);
    chk("R10 x on again", 64'(tx_x), 64'd0);
  endtask

  task automatic t_timers();
    do_reset();
    set_dtr(1);
    pulse_tick(9);
    chk("R11 T1 not yet", 64'(state), 64'd1);
    pulse_tick(1);
    chk("R11 T1 expired", 64'(state), 64'd0);
    step(2);
    chk("R11 idle holds w/o new rise", 64'(state), 64'd0);
    reach_data();
    set_dtr(0);
    pulse_tick(4);
    chk("R11 T2 not yet", 64'(state), 64'd3);
    pulse_tick(1);
    chk("R11 T2 expired", 64'(state), 64'd0);
    reach_data();
    pulse_desync();
    pulse_tick(2);
    chk("R11 X1 not yet", 64'(state), 64'd4);
    pulse_tick(1);
    chk("R11 X1 expired", 64'(state), 64'd3);
    chk("R11 X1 status/cts", 64'({status, cts}), 64'({8'h14, 1'b0}));
  endtask

  initial begin
    t_reset();
    t_idle();
    t_connect();
    t_data();
    t_local_disc();
    t_remote_disc();
    t_resync();
    t_timers();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule